// File: doc/BRIEF.md
# Paired-Block Interrupt Aggregator with Vector

This block gathers interrupt events from eight serial channels, grouped as four two-channel blocks, into one 8-bit status register per block. Each block also has an 8-bit mask register that the host writes. Each of the two interrupt request lines is shared by a pair of neighbouring blocks. A line is high while either block of its pair has a status bit set whose mask bit is also set. The request lines are combinational functions of the registered status and mask. A line therefore follows any change to those registers in the same cycle that the change becomes visible.

The channel logic reports its events through one-cycle set and clear strobes. Each channel has strobes for transmit-ready, receive-ready and break. Each block also has strobes for a counter-ready bit and an input-change bit, plus a command that clears the break bits of both channels of that block at once.

An 8-bit vector register holds the value the host gets back on an interrupt acknowledge. Two write strobes can load it: one from the identification space and one from the byte-wide memory space. An acknowledge read decodes its address combinationally and returns either the vector or zero.

Top module: `irq_pair_aggregator`

## Requirements
- R1: After reset, every status register, every mask register and the vector read as 0x00, and both request lines are low.
- R2: A set strobe for channel c sets bits in the status register of block c/2. For an even channel the bits are 0 (transmit-ready), 1 (receive-ready) and 2 (break). For an odd channel they are 4, 5 and 6. The new value reads back on `stat_rdata` in the cycle after the strobe.
- R3: A per-channel clear strobe clears the matching status bit in the cycle after the strobe. When a set strobe and a clear strobe hit the same bit in the same cycle, the bit ends up set.
- R4: The pair break-clear command for block b clears bits 2 and 6 of block b only. Every other bit of block b, and every other block, keeps its value.
- R5: The block-level counter-ready strobes set and clear bit 3. The block-level input-change strobes set and clear bit 7.
- R6: A mask write loads `mask_wdata` into the mask of the block chosen by `mask_sel`. The value reads back on `mask_rdata`, and the other masks keep their values.
- R7: Request line k is high exactly when block 2k or block 2k+1 has a nonzero AND of status and mask. The line follows a status or mask update in the cycle that update becomes visible.
- R8: A pulse on either `vec_id_we` or `vec_mem_we` loads `vec_wdata` into the vector register in the cycle after the pulse.
- R9: An acknowledge read at address 0 (line 0) or address 2 (line 1) returns the vector register in the same cycle. An acknowledge read at any other address, or no read at all, returns 0x00. An acknowledge read leaves the status, mask and request lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txr_set | input | 8 | Per-channel transmit-ready set strobes |
| txr_clr | input | 8 | Per-channel transmit-ready clear strobes |
| rxr_set | input | 8 | Per-channel receive-ready set strobes |
| rxr_clr | input | 8 | Per-channel receive-ready clear strobes |
| brk_set | input | 8 | Per-channel break set strobes |
| brk_clr | input | 8 | Per-channel break clear strobes |
| brk_pair_clr | input | 4 | Per-block command that clears both break bits |
| cnt_set | input | 4 | Per-block counter-ready set strobes |
| cnt_clr | input | 4 | Per-block counter-ready clear strobes |
| ipc_set | input | 4 | Per-block input-change set strobes |
| ipc_clr | input | 4 | Per-block input-change clear strobes |
| mask_we | input | 1 | Mask write strobe |
| mask_sel | input | 2 | Block whose mask is written |
| mask_wdata | input | 8 | Mask write data |
| rd_sel | input | 2 | Block shown on the read-back outputs |
| stat_rdata | output | 8 | Status of the selected block |
| mask_rdata | output | 8 | Mask of the selected block |
| vec_id_we | input | 1 | Vector load strobe from the identification space |
| vec_mem_we | input | 1 | Vector load strobe from a byte-wide memory write |
| vec_wdata | input | 8 | Vector write data |
| ack_rd | input | 1 | Acknowledge-space read strobe |
| ack_addr | input | 8 | Acknowledge-space address |
| ack_rdata | output | 8 | Acknowledge read data |
| irq_line | output | 2 | Interrupt request lines |

## Verification
The assertions assume that each strobe is either high for exactly one sampled cycle or held low. They also assume that `mask_sel` and `rd_sel` always name an existing block. The bench drives every strobe at the falling edge and drops it at the next falling edge, so each strobe covers exactly one rising edge. It only ever presents the four existing block indices. Set and clear strobes on the same bit are raised together on purpose, and only in the single test that covers that collision rule.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int STAT_W      = 8;
  localparam int HALF_STRIDE = 4;   // odd channel sits one nibble up
  localparam int TX_OFS      = 0;
  localparam int RX_OFS      = 1;
  localparam int BK_OFS      = 2;
  localparam int CNT_BIT     = 3;
  localparam int IPC_BIT     = 7;

  typedef logic [STAT_W-1:0] stat_t;

  function automatic int chan_bit(input int half, input int ofs);
    return half * HALF_STRIDE + ofs;
  endfunction
endpackage

// File: rtl/irq_stat_block.sv
module irq_stat_block
  import irq_agg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] tx_set,
  input  logic [1:0] tx_clr,
  input  logic [1:0] rx_set,
  input  logic [1:0] rx_clr,
  input  logic [1:0] bk_set,
  input  logic [1:0] bk_clr,
  input  logic       bk_pair_clr,
  input  logic       cnt_set,
  input  logic       cnt_clr,
  input  logic       ipc_set,
  input  logic       ipc_clr,
  input  logic       mask_we,
  input  stat_t      mask_wdata,
  output stat_t      stat_q,
  output stat_t      mask_q,
  output logic       hit
);
  stat_t set_v, clr_v;

  always_comb begin
    set_v = '0;
    clr_v = '0;
    for (int h = 0; h < 2; h++) begin
      set_v[chan_bit(h, TX_OFS)] = tx_set[h];
      set_v[chan_bit(h, RX_OFS)] = rx_set[h];
      set_v[chan_bit(h, BK_OFS)] = bk_set[h];
      clr_v[chan_bit(h, TX_OFS)] = tx_clr[h];
      clr_v[chan_bit(h, RX_OFS)] = rx_clr[h];
      clr_v[chan_bit(h, BK_OFS)] = bk_clr[h] | bk_pair_clr;
    end
    set_v[CNT_BIT] = cnt_set;
    set_v[IPC_BIT] = ipc_set;
    clr_v[CNT_BIT] = cnt_clr;
    clr_v[IPC_BIT] = ipc_clr;
  end

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wdata;
  end

  assign hit = |(stat_q & mask_q);
endmodule

// File: rtl/irq_line_or.sv
module irq_line_or #(
  parameter int NUM_BLOCKS      = 4,
  parameter int BLOCKS_PER_LINE = 2,
  localparam int NUM_LINES      = NUM_BLOCKS / BLOCKS_PER_LINE
) (
  input  logic [NUM_BLOCKS-1:0] hit,
  output logic [NUM_LINES-1:0]  line
);
  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    assign line[k] = |hit[k*BLOCKS_PER_LINE +: BLOCKS_PER_LINE];
  end
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit #(
  parameter int VEC_W     = 8,
  parameter int ACK_AW    = 8,
  parameter int NUM_LINES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_we,
  input  logic              mem_we,
  input  logic [VEC_W-1:0]  wdata,
  input  logic              ack_rd,
  input  logic [ACK_AW-1:0] ack_addr,
  output logic [VEC_W-1:0]  ack_rdata,
  output logic [VEC_W-1:0]  vec_q
);
  localparam logic [ACK_AW-1:0] ACK_END = ACK_AW'(2 * NUM_LINES);

  logic ack_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               vec_q <= '0;
    else if (id_we || mem_we) vec_q <= wdata;
  end

  // one acknowledge slot per line, on even addresses
  assign ack_hit   = ack_rd && !ack_addr[0] && (ack_addr < ACK_END);
  assign ack_rdata = ack_hit ? vec_q : '0;
endmodule

// File: rtl/irq_pair_aggregator.sv
module irq_pair_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int BLOCKS_PER_LINE = 2,
  parameter int ACK_AW          = 8,
  parameter int VEC_W           = 8,
  localparam int NUM_CH         = 2 * NUM_BLOCKS,
  localparam int NUM_LINES      = NUM_BLOCKS / BLOCKS_PER_LINE,
  localparam int BLK_IW         = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     txr_set,
  input  logic [NUM_CH-1:0]     txr_clr,
  input  logic [NUM_CH-1:0]     rxr_set,
  input  logic [NUM_CH-1:0]     rxr_clr,
  input  logic [NUM_CH-1:0]     brk_set,
  input  logic [NUM_CH-1:0]     brk_clr,
  input  logic [NUM_BLOCKS-1:0] brk_pair_clr,
  input  logic [NUM_BLOCKS-1:0] cnt_set,
  input  logic [NUM_BLOCKS-1:0] cnt_clr,
  input  logic [NUM_BLOCKS-1:0] ipc_set,
  input  logic [NUM_BLOCKS-1:0] ipc_clr,
  input  logic                  mask_we,
  input  logic [BLK_IW-1:0]     mask_sel,
  input  logic [STAT_W-1:0]     mask_wdata,
  input  logic [BLK_IW-1:0]     rd_sel,
  output logic [STAT_W-1:0]     stat_rdata,
  output logic [STAT_W-1:0]     mask_rdata,
  input  logic                  vec_id_we,
  input  logic                  vec_mem_we,
  input  logic [VEC_W-1:0]      vec_wdata,
  input  logic                  ack_rd,
  input  logic [ACK_AW-1:0]     ack_addr,
  output logic [VEC_W-1:0]      ack_rdata,
  output logic [NUM_LINES-1:0]  irq_line
);
  stat_t stat_arr [NUM_BLOCKS];
  stat_t mask_arr [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0]        blk_hit;
  logic [NUM_BLOCKS*STAT_W-1:0] stat_flat;
  logic [NUM_BLOCKS*STAT_W-1:0] mask_flat;
  logic [VEC_W-1:0]             vec_q;

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_blk
    irq_stat_block u_blk (
      .clk         (clk),
      .rst_n       (rst_n),
      .tx_set      (txr_set[2*g +: 2]),
      .tx_clr      (txr_clr[2*g +: 2]),
      .rx_set      (rxr_set[2*g +: 2]),
      .rx_clr      (rxr_clr[2*g +: 2]),
      .bk_set      (brk_set[2*g +: 2]),
      .bk_clr      (brk_clr[2*g +: 2]),
      .bk_pair_clr (brk_pair_clr[g]),
      .cnt_set     (cnt_set[g]),
      .cnt_clr     (cnt_clr[g]),
      .ipc_set     (ipc_set[g]),
      .ipc_clr     (ipc_clr[g]),
      .mask_we     (mask_we && (mask_sel == BLK_IW'(g))),
      .mask_wdata  (mask_wdata),
      .stat_q      (stat_arr[g]),
      .mask_q      (mask_arr[g]),
      .hit         (blk_hit[g])
    );
    assign stat_flat[g*STAT_W +: STAT_W] = stat_arr[g];
    assign mask_flat[g*STAT_W +: STAT_W] = mask_arr[g];
  end

  assign stat_rdata = stat_arr[rd_sel];
  assign mask_rdata = mask_arr[rd_sel];

  irq_line_or #(
    .NUM_BLOCKS      (NUM_BLOCKS),
    .BLOCKS_PER_LINE (BLOCKS_PER_LINE)
  ) u_or (
    .hit  (blk_hit),
    .line (irq_line)
  );

  irq_vec_unit #(
    .VEC_W     (VEC_W),
    .ACK_AW    (ACK_AW),
    .NUM_LINES (NUM_LINES)
  ) u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_we     (vec_id_we),
    .mem_we    (vec_mem_we),
    .wdata     (vec_wdata),
    .ack_rd    (ack_rd),
    .ack_addr  (ack_addr),
    .ack_rdata (ack_rdata),
    .vec_q     (vec_q)
  );
endmodule

// File: rtl/irq_pair_aggregator_chk.sv
module irq_pair_aggregator_chk
  import irq_agg_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int BLOCKS_PER_LINE = 2,
  parameter int ACK_AW          = 8,
  parameter int VEC_W           = 8,
  localparam int NUM_CH         = 2 * NUM_BLOCKS,
  localparam int NUM_LINES      = NUM_BLOCKS / BLOCKS_PER_LINE
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            txr_set,
  input logic [NUM_CH-1:0]            txr_clr,
  input logic [NUM_CH-1:0]            brk_set,
  input logic [NUM_BLOCKS-1:0]        brk_pair_clr,
  input logic [NUM_BLOCKS*STAT_W-1:0] stat_flat,
  input logic [NUM_BLOCKS*STAT_W-1:0] mask_flat,
  input logic [NUM_LINES-1:0]         irq_line,
  input logic                         ack_rd,
  input logic [ACK_AW-1:0]            ack_addr,
  input logic [VEC_W-1:0]             ack_rdata,
  input logic                         vec_id_we,
  input logic                         vec_mem_we,
  input logic [VEC_W-1:0]             vec_wdata,
  input logic [VEC_W-1:0]             vec_q
);
  logic [NUM_LINES-1:0] exp_line;
  logic                 ack_slot;

  always_comb begin
    exp_line = '0;
    for (int b = 0; b < NUM_BLOCKS; b++)
      if ((stat_flat[b*STAT_W +: STAT_W] & mask_flat[b*STAT_W +: STAT_W]) != '0)
        exp_line[b / BLOCKS_PER_LINE] = 1'b1;
  end

  assign ack_slot = (ack_addr == ACK_AW'(0)) || (ack_addr == ACK_AW'(2));

  p_lines_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_line == '0));

  p_line_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line == exp_line);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int SB = (c / 2) * STAT_W + chan_bit(c % 2, TX_OFS);
    p_tx_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      txr_set[c] |=> stat_flat[SB]);
    p_tx_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (txr_clr[c] && !txr_set[c]) |=> !stat_flat[SB]);
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_bk
    localparam int B0 = b * STAT_W + chan_bit(0, BK_OFS);
    localparam int B1 = b * STAT_W + chan_bit(1, BK_OFS);
    p_pair_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_pair_clr[b] && !brk_set[2*b] && !brk_set[2*b+1])
        |=> (!stat_flat[B0] && !stat_flat[B1]));
  end

  p_vec_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_id_we || vec_mem_we) |=> (vec_q == $past(vec_wdata)));

  p_ack_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_rd && ack_slot) |-> (ack_rdata == '0));

  p_ack_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && ack_slot) |-> (ack_rdata == vec_q));
endmodule

bind irq_pair_aggregator irq_pair_aggregator_chk #(
  .NUM_BLOCKS      (NUM_BLOCKS),
  .BLOCKS_PER_LINE (BLOCKS_PER_LINE),
  .ACK_AW          (ACK_AW),
  .VEC_W           (VEC_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .txr_set      (txr_set),
  .txr_clr      (txr_clr),
  .brk_set      (brk_set),
  .brk_pair_clr (brk_pair_clr),
  .stat_flat    (stat_flat),
  .mask_flat    (mask_flat),
  .irq_line     (irq_line),
  .ack_rd       (ack_rd),
  .ack_addr     (ack_addr),
  .ack_rdata    (ack_rdata),
  .vec_id_we    (vec_id_we),
  .vec_mem_we   (vec_mem_we),
  .vec_wdata    (vec_wdata),
  .vec_q        (vec_q)
);

// File: tb/irq_pair_aggregator_bench.sv
`timescale 1ns/1ps
module irq_pair_aggregator_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] txr_set = '0, txr_clr = '0, rxr_set = '0, rxr_clr = '0;
  logic [7:0] brk_set = '0, brk_clr = '0;
  logic [3:0] brk_pair_clr = '0, cnt_set = '0, cnt_clr = '0, ipc_set = '0, ipc_clr = '0;
  logic       mask_we = 1'b0;
  logic [1:0] mask_sel = '0, rd_sel = '0;
  logic [7:0] mask_wdata = '0, vec_wdata = '0, ack_addr = '0;
  logic       vec_id_we = 1'b0, vec_mem_we = 1'b0, ack_rd = 1'b0;
  logic [7:0] stat_rdata, mask_rdata, ack_rdata;
  logic [1:0] irq_line;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_pair_aggregator u_irq_pair_aggregator (
    .clk(clk), .rst_n(rst_n),
    .txr_set(txr_set), .txr_clr(txr_clr), .rxr_set(rxr_set), .rxr_clr(rxr_clr),
    .brk_set(brk_set), .brk_clr(brk_clr), .brk_pair_clr(brk_pair_clr),
    .cnt_set(cnt_set), .cnt_clr(cnt_clr), .ipc_set(ipc_set), .ipc_clr(ipc_clr),
    .mask_we(mask_we), .mask_sel(mask_sel), .mask_wdata(mask_wdata),
    .rd_sel(rd_sel), .stat_rdata(stat_rdata), .mask_rdata(mask_rdata),
    .vec_id_we(vec_id_we), .vec_mem_we(vec_mem_we), .vec_wdata(vec_wdata),
    .ack_rd(ack_rd), .ack_addr(ack_addr), .ack_rdata(ack_rdata),
    .irq_line(irq_line)
  );

  // entry: {channel[2:0], kind[1:0] (0 tx,1 rx,2 brk), block[1:0], expected status[7:0]}
  localparam logic [14:0] TBL [8] = '{
    {3'd0, 2'd0, 2'd0, 8'h01},
    {3'd1, 2'd1, 2'd0, 8'h21},
    {3'd1, 2'd2, 2'd0, 8'h61},
    {3'd2, 2'd1, 2'd1, 8'h02},
    {3'd5, 2'd0, 2'd2, 8'h10},
    {3'd6, 2'd2, 2'd3, 8'h04},
    {3'd7, 2'd0, 2'd3, 8'h14},
    {3'd3, 2'd2, 2'd1, 8'h42}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd_stat(input int b, output logic [7:0] s);
    @(negedge clk);
    rd_sel = 2'(b);
    #1 s = stat_rdata;
  endtask

  task automatic rd_mask(input int b, output logic [7:0] m);
    @(negedge clk);
    rd_sel = 2'(b);
    #1 m = mask_rdata;
  endtask

  task automatic write_mask(input int b, input logic [7:0] v);
    @(negedge clk);
    mask_we = 1'b1; mask_sel = 2'(b); mask_wdata = v;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic pulse_chan(input int ch, input int kind);
    @(negedge clk);
    case (kind)
      0: txr_set[ch] = 1'b1;
      1: rxr_set[ch] = 1'b1;
      default: brk_set[ch] = 1'b1;
    endcase
    @(negedge clk);
    txr_set = '0; rxr_set = '0; brk_set = '0;
  endtask

  task automatic ack_read(input logic [7:0] a, input logic rd, output logic [7:0] d);
    @(negedge clk);
    ack_rd = rd; ack_addr = a;
    #1 d = ack_rdata;
    @(negedge clk);
    ack_rd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int b = 0; b < 4; b++) begin
      rd_stat(b, v); chk("R1 status", v, 8'h00);
      rd_mask(b, v); chk("R1 mask", v, 8'h00);
    end
    chk("R1 lines", {6'd0, irq_line}, 8'h00);
    ack_read(8'h00, 1'b1, v); chk("R1 vector", v, 8'h00);

    // R2: table of set events, masks all zero so lines stay low (R7)
    for (int i = 0; i < 8; i++) begin
      pulse_chan(int'(TBL[i][14:12]), int'(TBL[i][11:10]));
      rd_stat(int'(TBL[i][9:8]), v);
      chk("R2 status after set", v, TBL[i][7:0]);
      chk("R7 lines with zero mask", {6'd0, irq_line}, 8'h00);
    end

    // R6/R7: mask writes drive lines
    write_mask(1, 8'h02);
    rd_mask(1, v); chk("R6 mask readback", v, 8'h02);
    rd_mask(0, v); chk("R6 other mask untouched", v, 8'h00);
    chk("R7 line0 from block1", {6'd0, irq_line}, 8'h01);
    write_mask(2, 8'h01);
    chk("R7 masked bit off", {6'd0, irq_line}, 8'h01);
    write_mask(2, 8'h10);
    chk("R7 line1 from block2", {6'd0, irq_line}, 8'h03);

    // R4: pair break clear
    @(negedge clk); brk_pair_clr = 4'b1000;
    @(negedge clk); brk_pair_clr = '0;
    rd_stat(3, v); chk("R4 block3 pair clear", v, 8'h10);
    rd_stat(2, v); chk("R4 neighbour untouched", v, 8'h10);
    @(negedge clk); brk_pair_clr = 4'b0001;
    @(negedge clk); brk_pair_clr = '0;
    rd_stat(0, v); chk("R4 block0 pair clear", v, 8'h21);

    // R3: clear strobe, and line follows (R7)
    @(negedge clk); rxr_clr[2] = 1'b1;
    @(negedge clk); rxr_clr = '0;
    rd_stat(1, v); chk("R3 rx clear", v, 8'h40);
    chk("R7 line0 drops", {6'd0, irq_line}, 8'h02);

    // R3: set and clear together keeps set
    @(negedge clk); txr_set[4] = 1'b1; txr_clr[4] = 1'b1;
    @(negedge clk); txr_set = '0; txr_clr = '0;
    rd_stat(2, v); chk("R3 set wins over clear", v, 8'h11);

    // R3: per-channel break set then clear
    pulse_chan(7, 2);
    rd_stat(3, v); chk("R3 odd break set", v, 8'h50);
    @(negedge clk); brk_clr[7] = 1'b1;
    @(negedge clk); brk_clr = '0;
    rd_stat(3, v); chk("R3 odd break clear", v, 8'h10);

    // R5: counter-ready and input-change bits
    @(negedge clk); cnt_set[0] = 1'b1;
    @(negedge clk); cnt_set = '0;
    rd_stat(0, v); chk("R5 counter set", v, 8'h29);
    @(negedge clk); ipc_set[0] = 1'b1;
    @(negedge clk); ipc_set = '0;
    rd_stat(0, v); chk("R5 input change set", v, 8'hA9);
    @(negedge clk); cnt_clr[0] = 1'b1; ipc_clr[0] = 1'b1;
    @(negedge clk); cnt_clr = '0; ipc_clr = '0;
    rd_stat(0, v); chk("R5 both cleared", v, 8'h21);

    // R8/R9: vector and acknowledge decode
    @(negedge clk); vec_id_we = 1'b1; vec_wdata = 8'h5A;
    @(negedge clk); vec_id_we = 1'b0;
    ack_read(8'h00, 1'b1, v); chk("R9 ack line0", v, 8'h5A);
    ack_read(8'h02, 1'b1, v); chk("R9 ack line1", v, 8'h5A);
    ack_read(8'h01, 1'b1, v); chk("R9 ack odd addr", v, 8'h00);
    ack_read(8'h04, 1'b1, v); chk("R9 ack addr 4", v, 8'h00);
    ack_read(8'h00, 1'b0, v); chk("R9 no read strobe", v, 8'h00);
    chk("R9 lines unchanged by ack", {6'd0, irq_line}, 8'h02);
    rd_stat(2, v); chk("R9 status unchanged by ack", v, 8'h11);
    @(negedge clk); vec_mem_we = 1'b1; vec_wdata = 8'hC3;
    @(negedge clk); vec_mem_we = 1'b0;
    ack_read(8'h02, 1'b1, v); chk("R8 memory-space load", v, 8'hC3);

    // R1: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_stat(2, v); chk("R1 status after reset", v, 8'h00);
    rd_mask(2, v); chk("R1 mask after reset", v, 8'h00);
    chk("R1 lines after reset", {6'd0, irq_line}, 8'h00);
    ack_read(8'h00, 1'b1, v); chk("R1 vector after reset", v, 8'h00);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule